// File: doc/BRIEF.md
# Current-Step Limiting Clock-Gate Scheduler

This block decides when each module of a cluster that shares one power-pin domain may have its clock gate opened or closed. Every module has a fixed current weight, the size of the supply-current step its clock gate causes when it changes state. The scheduler remembers the weights of the transitions it has granted in a short, sliding run of recent cycles. It lets a new transition through only when that remembered total plus the new weight stays within a threshold. Any other request waits, so steps that would arrive together are spread over time.

Gate-off requests come from idle decay counters, one per module. Gate-on requests come from accesses aimed at a gated module, and from a pre-decode hint that wakes the ALU modules before an ALU instruction reaches them. An access also withdraws a gate-off that has not yet been granted. The block drives one clock-gate enable per module, wired straight to that module's clock gater, and one ready flag per module for the pipeline stall logic. The window length and the threshold are captured from configuration inputs while reset is high.

Top module: `curstep_gate_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, every enable and ready output is 1 and the window holds no grants. The window length and the threshold are taken from cfg_win_len and cfg_thresh during reset.
- R2: A transition of module i is granted only if its weight plus the weights of all grants in the window is no more than the threshold. Gate-on and gate-off both count as positive weight. A request that does not fit is deferred.
- R3: With window length L, a transition granted at a clock edge counts against the decisions of exactly the L cycles that follow that edge. It no longer counts in the cycle after those.
- R4: At most one enable output changes per clock edge. Gate-on requests take priority over gate-off requests, and the lowest module index wins within each direction. Only that single winning candidate is tested against the budget in a cycle.
- R5: A deferred request stays pending without being reasserted and is retried every cycle until it is granted.
- R6: An access to an enabled module cancels its pending gate-off and any gate-off request in the same cycle. An access to a gated module raises a gate-on request.
- R7: The pre-decode hint acts as an access on every module selected by ALU_MASK. In the default build these are modules 2 and 3.
- R8: mod_ready[i] is 1 exactly when module i is enabled. It is 0 while the module is gated and while its gate-on is pending. A granted request changes gate_en and mod_ready at the clock edge that ends the request cycle.
- R9: A cfg_win_len of 0 is taken as 1, and a value above WIN_MAX is taken as WIN_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_len | input | LEN_W | Window length in cycles, captured during reset |
| cfg_thresh | input | SUM_W | Current-step threshold, captured during reset |
| mod_weight | input | N_MOD*WGT_W | Per-module weight magnitude. Module i is at bits [i*WGT_W +: WGT_W] |
| decay_idle | input | N_MOD | Gate-off request from each module's decay counter |
| mod_access | input | N_MOD | Access aimed at each module |
| alu_predecode | input | 1 | Pre-decode hint that an ALU instruction is coming |
| gate_en | output | N_MOD | Clock-gate enable per module, 1 = clock running |
| mod_ready | output | N_MOD | Ready flag per module for stall logic |

## Verification
The bench uses the defaults: four modules of 3 bits per weight, WIN_MAX of 8, and ALU_MASK covering modules 2 and 3. The weights are 3, 2, 1 and 1, with a window of 4 and a threshold of 3. With a weight of 3 equal to the threshold, one grant fills the whole budget. The exact cycle at which a grant ages out can then be seen from the port. The 2-weight and 1-weight modules give both exact fits (2+1) and refusals (2+2, 3+1), and the bench drives them to check priority, same-cycle cancellation and hint wake-up. Rebuilding the configuration with lengths 0 and 15 reaches both ends of the length clamp, and a threshold of 5 shows two back-to-back grants.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_dir_e;

    localparam int GRANT_IDX_W = 8;

    typedef struct packed {
        logic                   valid;
        gate_dir_e              dir;
        logic [GRANT_IDX_W-1:0] idx;
    } grant_t;

    function automatic int unsigned clamp_len(input int unsigned raw, input int unsigned max_len);
        if (raw == 0)
            return 1;
        else if (raw > max_len)
            return max_len;
        else
            return raw;
    endfunction

endpackage

// File: rtl/cgs_window.sv
module cgs_window #(
    parameter int WGT_W   = 3,
    parameter int WIN_MAX = 8,
    parameter int LEN_W   = $clog2(WIN_MAX + 1),
    parameter int SUM_W   = WGT_W + $clog2(WIN_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [WGT_W-1:0] push_w,
    output logic [SUM_W-1:0] win_sum
);
    import cgs_pkg::*;

    logic [LEN_W-1:0] len_q;
    logic [WGT_W-1:0] hist_q [WIN_MAX];

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= LEN_W'(clamp_len(int'(cfg_len), WIN_MAX));
    end

    // history: slot 0 holds the grant of the most recent edge
    generate
        for (genvar k = 0; k < WIN_MAX; k++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst)
                    hist_q[k] <= '0;
                else if (k == 0)
                    hist_q[k] <= push_w;
                else
                    hist_q[k] <= hist_q[(k == 0) ? 0 : k-1];
            end
        end
    endgenerate

    always_comb begin
        win_sum = '0;
        for (int k = 0; k < WIN_MAX; k++) begin
            if (LEN_W'(k) < len_q)
                win_sum = win_sum + SUM_W'(hist_q[k]);
        end
    end

    // R9: captured length always inside 1..WIN_MAX
    assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0) && (len_q <= LEN_W'(WIN_MAX)));

endmodule

// File: rtl/cgs_arbiter.sv
module cgs_arbiter #(
    parameter int N_MOD = 4,
    parameter int WGT_W = 3,
    parameter int SUM_W = 7
) (
    input  logic [N_MOD-1:0]       req_on,
    input  logic [N_MOD-1:0]       req_off,
    input  logic [N_MOD*WGT_W-1:0] weights,
    input  logic [SUM_W-1:0]       win_sum,
    input  logic [SUM_W-1:0]       thresh,
    output cgs_pkg::grant_t        gnt,
    output logic [WGT_W-1:0]       gnt_w
);
    import cgs_pkg::*;

    localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;

    logic [N_MOD-1:0] cand;
    logic [IDX_W-1:0] pick;
    logic [WGT_W-1:0] pick_w;
    logic             fits;
    logic             on_any;

    always_comb begin
        on_any = |req_on;
        cand   = on_any ? req_on : req_off;
        pick   = '0;
        for (int i = N_MOD - 1; i >= 0; i--) begin
            if (cand[i])
                pick = IDX_W'(i);
        end
        pick_w = weights[pick*WGT_W +: WGT_W];
        fits   = ({1'b0, win_sum} + (SUM_W+1)'(pick_w)) <= {1'b0, thresh};

        gnt.valid = (|cand) && fits;
        gnt.dir   = on_any ? GATE_ON : GATE_OFF;
        gnt.idx   = GRANT_IDX_W'(pick);
        gnt_w     = gnt.valid ? pick_w : '0;
    end

endmodule

// File: rtl/cgs_slot.sv
module cgs_slot (
    input  logic clk,
    input  logic rst,
    input  logic wake,
    input  logic idle_req,
    input  logic grant_on,
    input  logic grant_off,
    output logic en,
    output logic req_on,
    output logic req_off
);
    logic en_q;
    logic pend_on_q;
    logic pend_off_q;

    always_comb begin
        req_on  = (pend_on_q | wake) & ~en_q;
        req_off = (pend_off_q | idle_req) & en_q & ~wake;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b1;
            pend_on_q  <= 1'b0;
            pend_off_q <= 1'b0;
        end else begin
            if (grant_on)
                en_q <= 1'b1;
            else if (grant_off)
                en_q <= 1'b0;
            pend_on_q  <= req_on & ~grant_on;
            pend_off_q <= req_off & ~grant_off;
        end
    end

    assign en = en_q;

    // R6: a module never turns off in the cycle after it was accessed
    assert_no_off_on_access_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> !$past(wake));

    // R5: a module only turns on after an access or a retained request
    assert_on_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(wake || pend_on_q));

endmodule

// File: rtl/curstep_gate_sched.sv
module curstep_gate_sched #(
    parameter int               N_MOD    = 4,
    parameter int               WGT_W    = 3,
    parameter int               WIN_MAX  = 8,
    parameter logic [N_MOD-1:0] ALU_MASK = 4'b1100,
    parameter int               LEN_W    = $clog2(WIN_MAX + 1),
    parameter int               SUM_W    = WGT_W + $clog2(WIN_MAX) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LEN_W-1:0]       cfg_win_len,
    input  logic [SUM_W-1:0]       cfg_thresh,
    input  logic [N_MOD*WGT_W-1:0] mod_weight,
    input  logic [N_MOD-1:0]       decay_idle,
    input  logic [N_MOD-1:0]       mod_access,
    input  logic                   alu_predecode,
    output logic [N_MOD-1:0]       gate_en,
    output logic [N_MOD-1:0]       mod_ready
);
    import cgs_pkg::*;

    logic [SUM_W-1:0] thr_q;
    logic [SUM_W-1:0] win_sum;
    logic [WGT_W-1:0] gnt_w;
    grant_t           gnt;
    logic [N_MOD-1:0] wake_vec;
    logic [N_MOD-1:0] req_on;
    logic [N_MOD-1:0] req_off;
    logic [N_MOD-1:0] gon_vec;
    logic [N_MOD-1:0] goff_vec;

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= cfg_thresh;
    end

    assign wake_vec = mod_access | ({N_MOD{alu_predecode}} & ALU_MASK);

    cgs_window #(
        .WGT_W  (WGT_W),
        .WIN_MAX(WIN_MAX),
        .LEN_W  (LEN_W),
        .SUM_W  (SUM_W)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .cfg_len(cfg_win_len),
        .push_w (gnt_w),
        .win_sum(win_sum)
    );

    cgs_arbiter #(
        .N_MOD(N_MOD),
        .WGT_W(WGT_W),
        .SUM_W(SUM_W)
    ) u_arb (
        .req_on (req_on),
        .req_off(req_off),
        .weights(mod_weight),
        .win_sum(win_sum),
        .thresh (thr_q),
        .gnt    (gnt),
        .gnt_w  (gnt_w)
    );

    generate
        for (genvar i = 0; i < N_MOD; i++) begin : g_slot
            assign gon_vec[i]  = gnt.valid && (gnt.dir == GATE_ON)  && (gnt.idx == GRANT_IDX_W'(i));
            assign goff_vec[i] = gnt.valid && (gnt.dir == GATE_OFF) && (gnt.idx == GRANT_IDX_W'(i));

            cgs_slot u_slot (
                .clk      (clk),
                .rst      (rst),
                .wake     (wake_vec[i]),
                .idle_req (decay_idle[i]),
                .grant_on (gon_vec[i]),
                .grant_off(goff_vec[i]),
                .en       (gate_en[i]),
                .req_on   (req_on[i]),
                .req_off  (req_off[i])
            );
        end
    endgenerate

    assign mod_ready = gate_en;

    // R1: everything enabled right after reset
    assert_reset_all_on_R1: assert property (@(posedge clk)
        rst |=> (&gate_en));

    // R4: at most one enable changes per edge
    assert_one_step_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(gate_en ^ $past(gate_en)) <= 1);

    // R2: the windowed total never exceeds the threshold
    assert_budget_R2: assert property (@(posedge clk) disable iff (rst)
        win_sum <= thr_q);

    // R4: a gate-off is never granted while a gate-on is requested
    assert_on_first_R4: assert property (@(posedge clk) disable iff (rst)
        (|req_on) |=> ($countones(~gate_en & $past(gate_en)) == 0));

endmodule

// File: tb/test_curstep_gate_sched.sv
`timescale 1ns/1ps
module test_curstep_gate_sched;

    localparam int N   = 4;
    localparam int WW  = 3;
    localparam int WM  = 8;
    localparam int LW  = $clog2(WM + 1);
    localparam int SW  = WW + $clog2(WM) + 1;
    localparam int NV  = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] cfg_win_len = LW'(4);
    logic [SW-1:0] cfg_thresh  = SW'(3);
    logic [N*WW-1:0] mod_weight = {3'd1, 3'd1, 3'd2, 3'd3};
    logic [N-1:0]  decay_idle = '0;
    logic [N-1:0]  mod_access = '0;
    logic          alu_predecode = 1'b0;
    logic [N-1:0]  gate_en;
    logic [N-1:0]  mod_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    curstep_gate_sched i_curstep_gate_sched (
        .clk          (clk),
        .rst          (rst),
        .cfg_win_len  (cfg_win_len),
        .cfg_thresh   (cfg_thresh),
        .mod_weight   (mod_weight),
        .decay_idle   (decay_idle),
        .mod_access   (mod_access),
        .alu_predecode(alu_predecode),
        .gate_en      (gate_en),
        .mod_ready    (mod_ready)
    );

    // row: {idle[3:0], access[3:0], hint, expected enables[3:0]}
    // weights m0=3 m1=2 m2=1 m3=1, window 4, threshold 3
    localparam logic [12:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 1'b0, 4'b1110},  // 0  m0 off fits (3<=3)           R2
        {4'b0010, 4'b0000, 1'b0, 4'b1110},  // 1  m1 off 3+2>3 deferred        R2
        {4'b0000, 4'b0000, 1'b0, 4'b1110},  // 2  retried                      R5
        {4'b0000, 4'b0000, 1'b0, 4'b1110},  // 3
        {4'b0000, 4'b0000, 1'b0, 4'b1110},  // 4  last cycle m0 still counts   R3
        {4'b0000, 4'b0000, 1'b0, 4'b1100},  // 5  aged out, m1 off granted     R3
        {4'b0000, 4'b0001, 1'b0, 4'b1100},  // 6  access m0, 2+3>3             R6
        {4'b0000, 4'b0000, 1'b0, 4'b1100},  // 7
        {4'b0000, 4'b0000, 1'b0, 4'b1100},  // 8
        {4'b0000, 4'b0000, 1'b0, 4'b1100},  // 9
        {4'b0000, 4'b0000, 1'b0, 4'b1101},  // 10 m0 on                        R5
        {4'b0100, 4'b0100, 1'b0, 4'b1101},  // 11 same-cycle cancel            R6
        {4'b1000, 4'b0000, 1'b0, 4'b1101},  // 12 m3 off 3+1>3 pending
        {4'b0000, 4'b0000, 1'b1, 4'b1101},  // 13 hint cancels m3 pending      R7
        {4'b0000, 4'b0000, 1'b0, 4'b1101},  // 14
        {4'b0000, 4'b0000, 1'b0, 4'b1101},  // 15 window empty, m3 stays on    R7
        {4'b0100, 4'b0000, 1'b0, 4'b1001},  // 16 m2 off
        {4'b0000, 4'b0000, 1'b1, 4'b1101},  // 17 hint wakes m2 (1+1)          R7
        {4'b1000, 4'b0010, 1'b0, 4'b1101},  // 18 m1 on first, 2+2>3            R4
        {4'b0000, 4'b0000, 1'b0, 4'b1101},  // 19 head-of-line blocks m3 off   R4
        {4'b0000, 4'b0000, 1'b0, 4'b1101},  // 20
        {4'b0000, 4'b0000, 1'b0, 4'b1111},  // 21 m1 on (1+2)
        {4'b0000, 4'b0000, 1'b0, 4'b0111},  // 22 m3 off (2+1)
        {4'b0000, 4'b0000, 1'b0, 4'b0111},  // 23
        {4'b0000, 4'b0000, 1'b0, 4'b0111},  // 24
        {4'b0000, 4'b0000, 1'b0, 4'b0111},  // 25
        {4'b0000, 4'b0000, 1'b0, 4'b0111},  // 26
        {4'b0110, 4'b0000, 1'b0, 4'b0101},  // 27 lowest index m1 wins         R4
        {4'b0000, 4'b0000, 1'b0, 4'b0001}   // 28 m2 next (2+1)                R5
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input logic [N-1:0] idle, input logic [N-1:0] acc, input logic hint,
                        input logic [N-1:0] exp, input string tag);
        decay_idle    = idle;
        mod_access    = acc;
        alu_predecode = hint;
        @(posedge clk);
        @(negedge clk);
        check({tag, " enables"}, gate_en, exp);
        check("R8 ready", mod_ready, exp);
    endtask

    task automatic do_reset(input int len, input int thr);
        @(negedge clk);
        rst           = 1'b1;
        cfg_win_len   = LW'(len);
        cfg_thresh    = SW'(thr);
        decay_idle    = '0;
        mod_access    = '0;
        alu_predecode = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 reset enables", gate_en, 4'b1111);
        rst = 1'b0;
    endtask

    initial begin
        do_reset(4, 3);
        check("R1 reset ready", mod_ready, 4'b1111);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][12:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0], $sformatf("table row %0d", v));
        end

        // R9: length 0 behaves as 1
        do_reset(0, 3);
        step(4'b0001, 4'b0000, 1'b0, 4'b1110, "R9 len0 grant");
        step(4'b0010, 4'b0000, 1'b0, 4'b1110, "R9 len0 defer one cycle");
        step(4'b0000, 4'b0000, 1'b0, 4'b1100, "R9 len0 aged after one");

        // R9: length 15 behaves as 8
        do_reset(15, 3);
        step(4'b0001, 4'b0000, 1'b0, 4'b1110, "R9 len15 grant");
        step(4'b0010, 4'b0000, 1'b0, 4'b1110, "R9 len15 defer");
        for (int c = 0; c < 6; c++) begin
            step(4'b0000, 4'b0000, 1'b0, 4'b1110, "R9 len15 still deferred");
        end
        step(4'b0000, 4'b0000, 1'b0, 4'b1110, "R9 len15 eighth cycle");
        step(4'b0000, 4'b0000, 1'b0, 4'b1100, "R9 len15 aged after eight");

        // R2: larger threshold admits back-to-back grants (3 then 3+2)
        do_reset(4, 5);
        step(4'b0001, 4'b0000, 1'b0, 4'b1110, "R2 thr5 first");
        step(4'b0010, 4'b0000, 1'b0, 4'b1100, "R2 thr5 second fits");
        step(4'b0100, 4'b0000, 1'b0, 4'b1100, "R2 thr5 third 5+1 deferred");

        // R1: reset mid-run restores everything
        do_reset(4, 3);
        check("R1 mid-run reset ready", mod_ready, 4'b1111);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule